// File: doc/BRIEF.md
# Lane-Striped Multi-Port Register File

This block is a register file for a processor that issues two or four instructions per cycle. The registers are split into banks by the low bits of the register number, one bank per issue lane. Register `r` is stored in bank `r mod LANES`. Each lane has its own write data bus. A lane writes only into the bank that carries its own number, so the file needs no write multiplexer. Reads pass through a crossbar, so any lane can read any register.

Each lane gives its requests as one-hot vectors with one wire per register, not as encoded addresses. Every bank has a single read port. When lanes from different banks ask for data in the same cycle, all of them are served together. When several lanes ask the same bank in one cycle, a round-robin arbiter kept per bank serves one of them. The other lanes get a retry flag and present their request again.

Read results come out registered, one cycle after the request. A read and a write to the same register in the same cycle return the value held before that write. Dependency tracking and execution units sit outside this block.

Top module: `striped_regfile`

## Requirements
- R1: After reset every register holds zero, and `rd_valid` and `rd_retry` are low on all lanes.
- R2: Register `r` is stored in bank `r mod LANES`. A write by lane `l` to a register with `r mod LANES == l` is stored, and later reads of that register return the written data.
- R3: A write-enable bit set by lane `l` for a register with `r mod LANES != l` is ignored, and the register keeps its earlier value.
- R4: A read requested by any lane for any register gives `rd_valid` and the register contents on that lane in the next cycle. This includes registers held in another lane's bank.
- R5: When a register is read and written in the same cycle, the read returns the value from before the write. The new value is visible from the following cycle on.
- R6: When several lanes request the same bank in one cycle, exactly one of them gets `rd_valid` in the next cycle. Every other requesting lane gets `rd_retry` and no `rd_valid`.
- R7: Each bank's arbiter gives lane 0 the highest priority after reset. After granting lane `g`, the highest priority moves to lane `(g+1) mod LANES`. The priority does not change in a cycle with no grant.
- R8: Lanes that request different banks in the same cycle are all granted.
- R9: Each read-enable and write-enable vector has at most one bit set. A lane with no read request shows neither `rd_valid` nor `rd_retry` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | LANES x NREGS | One-hot read request per lane, one bit per register |
| wr_en | input | LANES x NREGS | One-hot write request per lane, one bit per register |
| wr_data | input | LANES x DATA_W | Write data per lane |
| rd_data | output | LANES x DATA_W | Read data per lane, registered |
| rd_valid | output | LANES | The lane's read from the previous cycle was served |
| rd_retry | output | LANES | The lane's read from the previous cycle lost arbitration |

## Verification
The hardest situation to reach from the ports is a priority pointer that has wrapped around under sustained contention, while other banks are busy in the same cycles. Only a run of cycles with several lanes aimed at one bank moves the pointer past every lane. The bench first holds all four lanes on a single bank for several cycles. It then sets two lanes against each other, and then runs a long random mix in which several lanes often land on the same bank. A behavioural model with its own pointers predicts the winner in every one of those cycles.

// File: rtl/srf_pkg.sv
package srf_pkg;
    // Per-lane read status as registered at the block's output
    typedef struct packed {
        logic valid;
        logic retry;
    } rd_status_t;

    // Bank that holds a register: low bits of its number
    function automatic int unsigned bank_of(input int unsigned reg_idx, input int unsigned lanes);
        return reg_idx % lanes;
    endfunction
endpackage

// File: rtl/srf_rr_arbiter.sv
module srf_rr_arbiter #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int unsigned PW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [PW-1:0] ptr;
    } arb_state_t;

    arb_state_t s_d, s_q;

    always_comb begin
        logic found;
        s_d   = s_q;
        gnt   = '0;
        found = 1'b0;
        for (int i = 0; i < int'(N); i++) begin
            int idx;
            idx = (int'(s_q.ptr) + i) % int'(N);
            if (!found && req[idx]) begin
                gnt[idx]  = 1'b1;
                found     = 1'b1;
                s_d.ptr   = PW'((idx + 1) % int'(N));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R6: never more than one winner, and only among requesters
    p_gnt_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    p_gnt_in_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
    // R8: a requested bank is never left idle
    p_no_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (|gnt));
    // R7: the priority holds when nothing was granted
    p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(|gnt) |=> $stable(s_q.ptr));
endmodule

// File: rtl/srf_bank.sv
module srf_bank #(
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEPTH-1:0]  wr_hot,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DEPTH-1:0]  rd_hot,
    output logic [DATA_W-1:0] rd_word
);
    logic [DEPTH-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        for (int j = 0; j < int'(DEPTH); j++) begin
            if (wr_hot[j]) mem_d[j] = wr_data;
        end
    end

    // AND-OR read mux from the one-hot select: reads pre-write contents
    always_comb begin
        rd_word = '0;
        for (int j = 0; j < int'(DEPTH); j++) begin
            rd_word = rd_word | (mem_q[j] & {DATA_W{rd_hot[j]}});
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    // R9: the crossbar hands each bank at most one row per port
    p_bank_wr_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_hot));
    p_bank_rd_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_hot));
    // R5: a written row takes the new data exactly one edge later
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hot != '0) |=> ((rd_hot != $past(wr_hot)) || (rd_word == $past(wr_data))));
endmodule

// File: rtl/striped_regfile.sv
module striped_regfile #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned DATA_W = 64,
    parameter int unsigned NREGS  = 128
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LANES-1:0][NREGS-1:0]   rd_en,
    input  logic [LANES-1:0][NREGS-1:0]   wr_en,
    input  logic [LANES-1:0][DATA_W-1:0]  wr_data,
    output logic [LANES-1:0][DATA_W-1:0]  rd_data,
    output logic [LANES-1:0]              rd_valid,
    output logic [LANES-1:0]              rd_retry
);
    import srf_pkg::*;

    localparam int unsigned DEPTH = NREGS / LANES;

    typedef struct packed {
        logic [LANES-1:0][DATA_W-1:0] data;
        rd_status_t [LANES-1:0]       st;
    } out_state_t;

    out_state_t s_d, s_q;

    logic [LANES-1:0][LANES-1:0]  bank_req;   // [bank][lane]
    logic [LANES-1:0][LANES-1:0]  bank_gnt;   // [bank][lane]
    logic [LANES-1:0][DEPTH-1:0]  bank_wr_hot;
    logic [LANES-1:0][DEPTH-1:0]  bank_rd_hot;
    logic [LANES-1:0][DATA_W-1:0] bank_word;

    // Fold per-register request wires into per-bank rows
    always_comb begin
        bank_req    = '0;
        bank_wr_hot = '0;
        for (int b = 0; b < int'(LANES); b++) begin
            for (int j = 0; j < int'(DEPTH); j++) begin
                // same-lane writes only: lane b owns bank b
                bank_wr_hot[b][j] = wr_en[b][j*int'(LANES)+b];
                for (int l = 0; l < int'(LANES); l++) begin
                    bank_req[b][l] = bank_req[b][l] | rd_en[l][j*int'(LANES)+b];
                end
            end
        end
    end

    // Winning lane steers its row select into the bank
    always_comb begin
        bank_rd_hot = '0;
        for (int b = 0; b < int'(LANES); b++) begin
            for (int l = 0; l < int'(LANES); l++) begin
                for (int j = 0; j < int'(DEPTH); j++) begin
                    bank_rd_hot[b][j] = bank_rd_hot[b][j]
                                      | (bank_gnt[b][l] & rd_en[l][j*int'(LANES)+b]);
                end
            end
        end
    end

    for (genvar b = 0; b < int'(LANES); b++) begin : g_bank
        srf_rr_arbiter #(.N(LANES)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (bank_req[b]),
            .gnt   (bank_gnt[b])
        );
        srf_bank #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hot  (bank_wr_hot[b]),
            .wr_data (wr_data[b]),
            .rd_hot  (bank_rd_hot[b]),
            .rd_word (bank_word[b])
        );
    end

    // Return crossbar: bank word back to the lane that won it
    always_comb begin
        s_d = '0;
        for (int l = 0; l < int'(LANES); l++) begin
            logic asked;
            asked = 1'b0;
            for (int b = 0; b < int'(LANES); b++) begin
                asked = asked | bank_req[b][l];
                if (bank_gnt[b][l]) begin
                    s_d.st[l].valid = 1'b1;
                    s_d.data[l]     = bank_word[b];
                end
            end
            s_d.st[l].retry = asked & ~s_d.st[l].valid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        for (int l = 0; l < int'(LANES); l++) begin
            rd_data[l]  = s_q.data[l];
            rd_valid[l] = s_q.st[l].valid;
            rd_retry[l] = s_q.st[l].retry;
        end
    end

    for (genvar l = 0; l < int'(LANES); l++) begin : g_lane_chk
        // R9: one-hot request vectors
        p_rd_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(rd_en[l]));
        p_wr_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(wr_en[l]));
        // R9: no request, no response
        p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en[l] == '0) |=> (!rd_valid[l] && !rd_retry[l]));
        // R6: served and refused never together
        p_valid_retry_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !(rd_valid[l] && rd_retry[l]));
        // R4: a request always produces a response next cycle
        p_req_answered_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en[l] != '0) |=> (rd_valid[l] || rd_retry[l]));
    end
endmodule

// File: tb/striped_regfile_test.sv
module striped_regfile_test;
    localparam int L  = 4;
    localparam int DW = 64;
    localparam int NR = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [L-1:0][NR-1:0] rd_en;
    logic [L-1:0][NR-1:0] wr_en;
    logic [L-1:0][DW-1:0] wr_data;
    logic [L-1:0][DW-1:0] rd_data;
    logic [L-1:0]         rd_valid;
    logic [L-1:0]         rd_retry;

    always #5 clk = ~clk;

    striped_regfile #(.LANES(L), .DATA_W(DW), .NREGS(NR)) uut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid), .rd_retry(rd_retry)
    );

    // Behavioural model
    logic [DW-1:0] m_mem [NR];
    int            m_ptr [L];
    int            rreg  [L];
    int            wreg  [L];
    logic [DW-1:0] wdat  [L];
    logic          e_val [L];
    logic          e_ret [L];
    logic [DW-1:0] e_dat [L];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic check(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive();
        for (int l = 0; l < L; l++) begin
            rd_en[l]   = '0;
            wr_en[l]   = '0;
            wr_data[l] = wdat[l];
            if (rreg[l] >= 0) rd_en[l][rreg[l]] = 1'b1;
            if (wreg[l] >= 0) wr_en[l][wreg[l]] = 1'b1;
        end
    endtask

    task automatic idle_all();
        for (int l = 0; l < L; l++) begin
            rreg[l] = -1; wreg[l] = -1; wdat[l] = '0;
        end
    endtask

    // One clock: predict, advance, compare
    task automatic tick(input string tag);
        drive();
        for (int l = 0; l < L; l++) begin
            e_val[l] = 0; e_ret[l] = 0; e_dat[l] = '0;
        end
        for (int b = 0; b < L; b++) begin
            int winner;
            winner = -1;
            for (int i = 0; i < L; i++) begin
                int c;
                c = (m_ptr[b] + i) % L;
                if (winner < 0 && rreg[c] >= 0 && rreg[c] % L == b) winner = c;
            end
            for (int l = 0; l < L; l++) begin
                if (rreg[l] >= 0 && rreg[l] % L == b) begin
                    if (l == winner) begin
                        e_val[l] = 1; e_dat[l] = m_mem[rreg[l]];
                    end else e_ret[l] = 1;
                end
            end
            if (winner >= 0) m_ptr[b] = (winner + 1) % L;
        end
        for (int l = 0; l < L; l++)
            if (wreg[l] >= 0 && wreg[l] % L == l) m_mem[wreg[l]] = wdat[l];
        @(posedge clk);
        #1;
        for (int l = 0; l < L; l++) begin
            check(tag, $sformatf("lane%0d valid", l), DW'(rd_valid[l]), DW'(e_val[l]));
            check(tag, $sformatf("lane%0d retry", l), DW'(rd_retry[l]), DW'(e_ret[l]));
            if (e_val[l]) check(tag, $sformatf("lane%0d data", l), rd_data[l], e_dat[l]);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NR; r++) m_mem[r] = '0;
        for (int b = 0; b < L; b++) m_ptr[b] = 0;
        idle_all();
        drive();
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs quiet under reset
        for (int l = 0; l < L; l++) begin
            check("R1", "reset valid", DW'(rd_valid[l]), '0);
            check("R1", "reset retry", DW'(rd_retry[l]), '0);
        end
        rst_n = 1'b1;
        tick("R9");
        // R1/R8: every register reads zero, four banks in parallel
        for (int c = 0; c < NR / L; c++) begin
            idle_all();
            for (int l = 0; l < L; l++) rreg[l] = c * L + l;
            tick("R1");
        end
        // R2: own-lane writes
        for (int c = 0; c < NR / L; c++) begin
            idle_all();
            for (int l = 0; l < L; l++) begin
                wreg[l] = c * L + l;
                wdat[l] = {32'(c * L + l), 32'hC0DE_0000 ^ 32'(l)};
            end
            tick("R2");
        end
        // R4: cross-lane reads
        for (int c = 0; c < NR / L; c++) begin
            idle_all();
            for (int l = 0; l < L; l++) rreg[l] = c * L + ((l + 1) % L);
            tick("R4");
        end
        // R3: wrong-lane writes are dropped, then read back
        for (int c = 0; c < 4; c++) begin
            idle_all();
            for (int l = 0; l < L; l++) begin
                wreg[l] = c * L + ((l + 1) % L);
                wdat[l] = 64'hDEAD_BEEF_0000_0000 | 64'(c);
            end
            tick("R3");
        end
        for (int c = 0; c < 4; c++) begin
            idle_all();
            for (int l = 0; l < L; l++) rreg[l] = c * L + l;
            tick("R3");
        end
        // R5: read and write of the same register in one cycle
        idle_all();
        wreg[0] = 8; wdat[0] = 64'h1111_2222_3333_4444; rreg[1] = 8;
        tick("R5");
        idle_all();
        rreg[1] = 8;
        tick("R5");
        // R6/R7: all lanes on bank 2
        for (int c = 0; c < 6; c++) begin
            idle_all();
            for (int l = 0; l < L; l++) rreg[l] = 2 + 4 * l;
            tick("R6");
        end
        // R7: two lanes alternate on bank 3
        for (int c = 0; c < 4; c++) begin
            idle_all();
            rreg[1] = 3; rreg[3] = 7;
            tick("R7");
        end
        // R8: random mix of reads and writes
        for (int c = 0; c < 400; c++) begin
            idle_all();
            for (int l = 0; l < L; l++) begin
                if ($urandom % 4 != 0) rreg[l] = int'($urandom % NR);
                if ($urandom % 2 == 0) begin
                    wreg[l] = ($urandom % 8 == 0) ? int'($urandom % NR)
                                                  : int'(($urandom % (NR / L)) * L + l);
                    wdat[l] = {$urandom, $urandom};
                end
            end
            tick("R8");
        end
        idle_all();
        tick("R9");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule